// File: doc/BRIEF.md
# Dual-Source Serial Baud Tick Generator

This block produces the 16x oversampling enable for a 16550-style serial port. A 16-bit divisor latch, loaded one byte at a time through the shared register window, sets the rate. The low fifteen bits of the latch are the count. The top bit picks one of two internal reference clocks, a slow one (1.8432 MHz class) or a fast one (48 MHz class). A separate configuration input can route an external clock pin in place of both internal references. The output tick rate is the selected source rate divided by the count. The serial bit rate is that tick rate divided by sixteen.

All reference clocks arrive as single-cycle enables in the system clock domain. The generator counts only while the activate input is high. While activate is low the count is frozen and the clock-request output drops, which lets the clock controller gate the block. Writing either latch byte restarts the count from the new divisor, so a rate change never finishes an old period.

Top module: `baud_tick_gen`

## Requirements
- R1: With a non-zero count N in latch bits 14:0, `tick_x16` is high for one cycle, one clock after the Nth selected-source enable that follows the last reload or tick.
- R2: With `ext_clk_sel` low, latch bit 15 picks the source: 0 counts `ref_slow_en` and 1 counts `ref_fast_en`.
- R3: With `ext_clk_sel` high, only `ext_clk_en` is counted, and latch bit 15 has no effect.
- R4: A write with `div_access` high and `win_addr` 0 loads latch bits 7:0, and with `win_addr` 1 loads bits 15:8. `div_rdata` shows the latch from the next cycle on.
- R5: A window write with `div_access` low changes neither the latch nor the count in progress.
- R6: While latch bits 14:0 are zero, `tick_x16` stays low whatever the sources do, including when bit 15 is set.
- R7: A latch write reloads the count, and no tick is issued in the cycle after it. The next tick comes after exactly N source enables of the new divisor.
- R8: While `act_en` is low no enable is counted and no tick is issued. The count resumes where it stopped. `clk_req` follows `act_en` one cycle later.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears the latch, the count, `tick_x16` and `clk_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_en | input | 1 | Block activate; generator runs only while high |
| ext_clk_sel | input | 1 | Configuration bit: count the external clock enable |
| ref_slow_en | input | 1 | Slow internal reference, one-cycle enable |
| ref_fast_en | input | 1 | Fast internal reference, one-cycle enable |
| ext_clk_en | input | 1 | External clock pin, as a one-cycle enable |
| win_we | input | 1 | Register window write strobe |
| win_addr | input | 1 | Window offset: 0 low byte, 1 high byte |
| win_wdata | input | 8 | Window write data |
| div_access | input | 1 | Divisor access bit from the line control register |
| tick_x16 | output | 1 | One-cycle 16x baud enable |
| div_rdata | output | 16 | Divisor latch readback |
| clk_req | output | 1 | Clock request, registered copy of act_en |

## Verification
The bench aims at the source choice. It moves bit 15 between the two internal references and turns on the external override. A design that ignored the override, or read the select bit backwards, would tick at the wrong enable stream's rate. It rewrites the divisor in the middle of a count, where a design without reload would issue a stray early or late tick. It also sends window writes with the access bit low, which a careless decode would let into the latch. Zero counts, with and without bit 15, must stay silent instead of wrapping to a 32768-enable period. Pausing activate mid-count must neither lose nor add enables.

// File: rtl/baud_pkg.sv
// Shared types for the baud tick generator.
// Assumes: nothing beyond IEEE 1800-2017.
package baud_pkg;

    // Which enable stream the counter consumes.
    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_EXT  = 2'd2
    } src_kind_e;

endpackage

// File: rtl/baud_div_latch.sv
// Divisor latch: two byte-wide halves written through the register window.
// Assumes: write strobe is a single-cycle qualified pulse from the top.
// Presents the value the latch will hold after this edge, for counter reload.
module baud_div_latch #(
    parameter int BYTE_W = 8,
    localparam int LATCH_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [LATCH_W-1:0] latch_q,
    output logic [LATCH_W-1:0] latch_next
);

    // Merge the written byte into the held value.
    always_comb begin
        latch_next = latch_q;
        if (wr_en) begin
            if (wr_hi) latch_next[LATCH_W-1:BYTE_W] = wr_data;
            else       latch_next[BYTE_W-1:0]       = wr_data;
        end
    end

    // Hold the divisor; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_next;
    end

endmodule

// File: rtl/baud_src_mux.sv
// Source selector: picks one of three enable streams.
// Assumes: all enables are synchronous to clk and one cycle wide.
// The external selection overrides the internal select bit.
module baud_src_mux
    import baud_pkg::*;
(
    input  logic      ext_sel,
    input  logic      fast_sel,
    input  logic      slow_en,
    input  logic      fast_en,
    input  logic      ext_en,
    output src_kind_e kind,
    output logic      src_en
);

    // Decide which source is active.
    always_comb begin
        if (ext_sel)       kind = SRC_EXT;
        else if (fast_sel) kind = SRC_FAST;
        else               kind = SRC_SLOW;
    end

    // Forward that source's enable.
    always_comb begin
        unique case (kind)
            SRC_FAST: src_en = fast_en;
            SRC_EXT:  src_en = ext_en;
            default:  src_en = slow_en;
        endcase
    end

endmodule

// File: rtl/baud_down_cnt.sv
// Down-counter that emits a registered tick every DIV source enables.
// Assumes: load has priority and suppresses the tick for that cycle.
// A zero divisor parks the counter and keeps the tick low.
module baud_down_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] div_val,
    input  logic             src_en,
    output logic             tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             div_zero;
    logic             at_term;

    // Terminal count and zero-divisor detection.
    assign div_zero = (div_val == '0);
    assign at_term  = (cnt_q <= ONE);

    // Count selected enables, reload and pulse at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            tick  <= 1'b0;
        end else if (run && !div_zero && src_en) begin
            if (at_term) begin
                cnt_q <= div_val;
                tick  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - ONE;
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
// Top: dual-source baud tick generator for a 16550-style serial port.
// Assumes: divisor access bit and window strobes come from the register
// decoder; reference clocks arrive as enables in the clk domain.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int LATCH_W = 2 * BYTE_W,
    localparam int CNT_W = LATCH_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_en,
    input  logic               ext_clk_sel,
    input  logic               ref_slow_en,
    input  logic               ref_fast_en,
    input  logic               ext_clk_en,
    input  logic               win_we,
    input  logic               win_addr,
    input  logic [BYTE_W-1:0]  win_wdata,
    input  logic               div_access,
    output logic               tick_x16,
    output logic [LATCH_W-1:0] div_rdata,
    output logic               clk_req
);

    logic               latch_wr;
    logic [LATCH_W-1:0] latch_q;
    logic [LATCH_W-1:0] latch_next;
    src_kind_e          kind;
    logic               src_en;

    // Only window writes with divisor access set reach the latch.
    assign latch_wr  = win_we && div_access;
    assign div_rdata = latch_q;

    baud_div_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (latch_wr),
        .wr_hi      (win_addr),
        .wr_data    (win_wdata),
        .latch_q    (latch_q),
        .latch_next (latch_next)
    );

    baud_src_mux u_mux (
        .ext_sel  (ext_clk_sel),
        .fast_sel (latch_q[LATCH_W-1]),
        .slow_en  (ref_slow_en),
        .fast_en  (ref_fast_en),
        .ext_en   (ext_clk_en),
        .kind     (kind),
        .src_en   (src_en)
    );

    baud_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (act_en),
        .load     (latch_wr),
        .load_val (latch_next[CNT_W-1:0]),
        .div_val  (latch_q[CNT_W-1:0]),
        .src_en   (src_en),
        .tick     (tick_x16)
    );

    // Clock request mirrors activate one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_req <= 1'b0;
        else        clk_req <= act_en;
    end

endmodule

// File: rtl/baud_tick_gen_chk.sv
// Port-level checker for baud_tick_gen, attached by bind below.
module baud_tick_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        act_en,
    input logic        win_we,
    input logic        win_addr,
    input logic [7:0]  win_wdata,
    input logic        div_access,
    input logic        tick_x16,
    input logic [15:0] div_rdata,
    input logic        clk_req
);

    // R6: zero count never ticks.
    a_r6_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rdata[14:0] == 15'd0) |-> !tick_x16);

    // R8: no tick while inactive.
    a_r8_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> !tick_x16);

    // R8: clock request tracks activate.
    a_r8_clk_req_up: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> clk_req);
    a_r8_clk_req_down: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> !clk_req);

    // R5: latch holds without a qualified write.
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we && div_access) |=> $stable(div_rdata));

    // R4: byte lanes land where addressed.
    a_r4_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && div_access && !win_addr) |=> (div_rdata[7:0] == $past(win_wdata)));
    a_r4_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && div_access && win_addr) |=> (div_rdata[15:8] == $past(win_wdata)));

    // R7: a reload cycle issues no tick.
    a_r7_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && div_access) |=> !tick_x16);

endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_en     (act_en),
    .win_we     (win_we),
    .win_addr   (win_addr),
    .win_wdata  (win_wdata),
    .div_access (div_access),
    .tick_x16   (tick_x16),
    .div_rdata  (div_rdata),
    .clk_req    (clk_req)
);

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_en = 1'b0;
    logic        ext_clk_sel = 1'b0;
    logic        ref_slow_en = 1'b0;
    logic        ref_fast_en = 1'b0;
    logic        ext_clk_en = 1'b0;
    logic        win_we = 1'b0;
    logic        win_addr = 1'b0;
    logic [7:0]  win_wdata = 8'h00;
    logic        div_access = 1'b0;
    logic        tick_x16;
    logic [15:0] div_rdata;
    logic        clk_req;

    always #2.5 clk = ~clk;

    baud_tick_gen uut (
        .clk (clk), .rst_n (rst_n), .act_en (act_en), .ext_clk_sel (ext_clk_sel),
        .ref_slow_en (ref_slow_en), .ref_fast_en (ref_fast_en), .ext_clk_en (ext_clk_en),
        .win_we (win_we), .win_addr (win_addr), .win_wdata (win_wdata),
        .div_access (div_access), .tick_x16 (tick_x16), .div_rdata (div_rdata),
        .clk_req (clk_req)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R9";

    // Behavioural reference state.
    int m_latch = 0;
    int m_seen  = 0;
    bit m_tick  = 0;
    bit m_req   = 0;

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // One clock: drive enables, predict, let the edge pass, compare at negedge.
    task automatic step();
        int  cnt_div;
        bit  sel;
        ref_slow_en = (cyc % 5 == 0);
        ref_fast_en = (cyc % 2 == 0);
        ext_clk_en  = (cyc % 3 == 0);
        cnt_div = m_latch % 32768;
        if (ext_clk_sel)        sel = ext_clk_en;
        else if (m_latch >= 32768) sel = ref_fast_en;
        else                    sel = ref_slow_en;
        if (!rst_n) begin
            m_latch = 0; m_seen = 0; m_tick = 0; m_req = 0;
        end else begin
            m_req = act_en;
            if (win_we && div_access) begin
                if (win_addr) m_latch = (m_latch % 256) + 256 * win_wdata;
                else          m_latch = (m_latch / 256) * 256 + win_wdata;
                m_seen = 0;
                m_tick = 0;
            end else if (act_en && cnt_div != 0 && sel) begin
                m_seen++;
                m_tick = (m_seen >= cnt_div);
                if (m_tick) m_seen = 0;
            end else begin
                m_tick = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        cmp("tick_x16", tick_x16, m_tick);
        cmp("div_rdata", div_rdata, m_latch);
        cmp("clk_req", clk_req, m_req);
        win_we = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(bit hi, logic [7:0] d, bit acc);
        win_we = 1'b1; win_addr = hi; win_wdata = d; div_access = acc;
        step();
        div_access = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R9"; act_en = 1'b1;
        run(3);
        rst_n = 1'b1; act_en = 1'b1;
        tag = "R4"; wr(0, 8'h03, 1); wr(1, 8'h00, 1);
        cmp("R4 low byte readback", div_rdata, 16'h0003);
        tag = "R1"; run(40);
        tag = "R2"; wr(1, 8'h80, 1);
        cmp("R2 select bit readback", div_rdata, 16'h8003);
        run(30);
        tag = "R3"; ext_clk_sel = 1'b1; run(30);
        wr(1, 8'h00, 1); run(30);
        ext_clk_sel = 1'b0;
        tag = "R5"; run(4);
        wr(0, 8'h55, 0); wr(1, 8'hAA, 0);
        cmp("R5 latch unchanged", div_rdata, 16'h0003);
        run(20);
        tag = "R7"; run(7); wr(0, 8'h05, 1); run(40);
        wr(1, 8'h80, 1); run(3); wr(0, 8'h02, 1); run(20);
        tag = "R8"; run(3); act_en = 1'b0; run(12); act_en = 1'b1; run(20);
        tag = "R6"; wr(0, 8'h00, 1); run(20); wr(1, 8'h00, 1); run(20);
        tag = "R9"; wr(0, 8'h04, 1); run(5); rst_n = 1'b0; run(2);
        cmp("R9 latch cleared", div_rdata, 0);
        rst_n = 1'b1; run(5);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule